// File: doc/BRIEF.md
# Timed Interrupt-Disable Countdown

This block holds off maskable interrupts for a programmed number of instruction cycles. A dedicated disable command loads a cycle count into a down-counter. While the count is non-zero, requests at user levels 1 through 6 are held back and a status flag reads 1. The count drops by one on every instruction-cycle strobe, stall cycles included. Reaching zero releases the mask.

Software may read the live count and may write or add to it. A write or add takes effect only while a window is already open, so it can shorten, end or extend the window but never open one. Level 7 requests and the trap levels (8 to 15) are never held back. The surrounding arbiter presents the level of the request it wants to take and gets back a single blocked flag.

Top module: `intdis_timer`

## Requirements
- R1: After reset the count is 0, the status flag is 0, and no level is blocked.
- R2: A disable command loads its count operand into the counter, and the status flag reads 1 from the next cycle if that operand is non-zero. A command carrying 0 leaves no window open.
- R3: While the count is non-zero, each cycle with the instruction-cycle strobe high lowers it by exactly 1. A cycle with the strobe low leaves it unchanged. At zero it stays at zero.
- R4: While the count is non-zero, a request level from 1 to 6 reads as blocked. Levels 0, 7 and 8 to 15 never read as blocked. The level input is 4 bits wide, with 8 to 15 meaning traps.
- R5: A software write while the count is non-zero replaces the count with the written value. Writing 0 ends the window at once.
- R6: A software write or add while the count is zero leaves the count at zero and the status flag at 0.
- R7: A software add while the count is non-zero adds the operand and saturates at 16383 instead of wrapping.
- R8: When several updates come in the same cycle, the priority is disable command first, then write, then add. Any of these updates suppresses the decrement for that cycle.
- R9: The status flag equals 1 exactly when the readable count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick_i | input | 1 | Instruction-cycle strobe, high on stall cycles too |
| dis_cmd_i | input | 1 | Disable command: load the counter |
| dis_len_i | input | 14 | Cycle count carried by the disable command |
| sw_wr_i | input | 1 | Software write of the counter |
| sw_add_i | input | 1 | Software add to the counter |
| sw_data_i | input | 14 | Operand for the write or add |
| req_lvl_i | input | 4 | Level of the request being considered |
| cnt_o | output | 14 | Current count, readable by software |
| active_o | output | 1 | Status flag: a disable window is open |
| req_blocked_o | output | 1 | The presented level is held back |

## Verification
The countdown is driven with the strobe both continuous and gapped. This separates a decrement taken per strobe from one taken per clock.

Writes and adds are applied once with the counter busy and once with it idle. This separates extending a window from starting one. Adds near the top of the range show saturation as opposed to wrap-around.

Updates are made to collide with one another and with the strobe, which exposes the update priority. The level probe sweeps 0, the edges 1 and 6, then 7 and trap values, both inside and outside a window.

// File: rtl/intdis_pkg.sv
package intdis_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2,
        OP_ADD   = 2'd3
    } upd_op_e;

    localparam int LVL_W       = 4;
    localparam int MASK_LO_LVL = 1;
    localparam int MASK_HI_LVL = 6;

endpackage

// File: rtl/intdis_arb.sv
module intdis_arb
    import intdis_pkg::*;
(
    input  logic    cmd_i,
    input  logic    wr_i,
    input  logic    add_i,
    output upd_op_e op_o
);
    // Fixed priority: command, then write, then add.
    always_comb begin
        if (cmd_i)      op_o = OP_LOAD;
        else if (wr_i)  op_o = OP_WRITE;
        else if (add_i) op_o = OP_ADD;
        else            op_o = OP_NONE;
    end
endmodule

// File: rtl/intdis_next.sv
module intdis_next
    import intdis_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  upd_op_e          op_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] opnd_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             live;
    logic [CNT_W:0]   sum_w;
    logic [CNT_W-1:0] sat_sum;

    assign live    = (cnt_i != '0);
    assign sum_w   = {1'b0, cnt_i} + {1'b0, opnd_i};
    assign sat_sum = sum_w[CNT_W] ? CNT_MAX : sum_w[CNT_W-1:0];

    always_comb begin
        cnt_o = cnt_i;
        unique case (op_i)
            OP_LOAD:  cnt_o = load_i;
            OP_WRITE: if (live) cnt_o = opnd_i;
            OP_ADD:   if (live) cnt_o = sat_sum;
            default:  if (live && tick_i) cnt_o = cnt_i - 1'b1;
        endcase
    end
endmodule

// File: rtl/intdis_gate.sv
module intdis_gate
    import intdis_pkg::*;
(
    input  logic             mask_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             blocked_o
);
    logic in_band;
    assign in_band   = (lvl_i >= LVL_W'(MASK_LO_LVL)) && (lvl_i <= LVL_W'(MASK_HI_LVL));
    assign blocked_o = mask_i && in_band;
endmodule

// File: rtl/intdis_timer.sv
module intdis_timer
    import intdis_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick_i,
    input  logic             dis_cmd_i,
    input  logic [CNT_W-1:0] dis_len_i,
    input  logic             sw_wr_i,
    input  logic             sw_add_i,
    input  logic [CNT_W-1:0] sw_data_i,
    input  logic [LVL_W-1:0] req_lvl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o,
    output logic             req_blocked_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } state_t;

    state_t           st_d, st_q;
    upd_op_e          op_w;
    logic [CNT_W-1:0] cnt_nxt_w;

    intdis_arb u_arb (
        .cmd_i (dis_cmd_i),
        .wr_i  (sw_wr_i),
        .add_i (sw_add_i),
        .op_o  (op_w)
    );

    intdis_next #(.CNT_W(CNT_W)) u_next (
        .cnt_i  (st_q.cnt),
        .op_i   (op_w),
        .load_i (dis_len_i),
        .opnd_i (sw_data_i),
        .tick_i (cyc_tick_i),
        .cnt_o  (cnt_nxt_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = cnt_nxt_w;
        st_d.busy = (cnt_nxt_w != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    intdis_gate u_gate (
        .mask_i    (st_q.busy),
        .lvl_i     (req_lvl_i),
        .blocked_o (req_blocked_o)
    );

    assign cnt_o    = st_q.cnt;
    assign active_o = st_q.busy;
endmodule

// File: rtl/intdis_timer_chk.sv
module intdis_timer_chk
    import intdis_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_tick_i,
    input logic             dis_cmd_i,
    input logic             sw_wr_i,
    input logic             sw_add_i,
    input logic [LVL_W-1:0] req_lvl_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             active_o,
    input logic             req_blocked_o
);
    logic quiet;
    assign quiet = !dis_cmd_i && !sw_wr_i && !sw_add_i;

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && cyc_tick_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !cyc_tick_i) |=> $stable(cnt_o));

    a_r6_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_cmd_i && cnt_o == '0) |=> (cnt_o == '0 && !active_o));

    a_r7_add_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_cmd_i && !sw_wr_i && sw_add_i) |=> (cnt_o >= $past(cnt_o)));

    a_r4_top_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lvl_i >= LVL_W'(7) || req_lvl_i == '0) |-> !req_blocked_o);

    a_r4_band_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != '0 && req_lvl_i >= LVL_W'(1) && req_lvl_i <= LVL_W'(6)) |-> req_blocked_o);

    a_r9_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        active_o == (cnt_o != '0));
endmodule

bind intdis_timer intdis_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_tick_i    (cyc_tick_i),
    .dis_cmd_i     (dis_cmd_i),
    .sw_wr_i       (sw_wr_i),
    .sw_add_i      (sw_add_i),
    .req_lvl_i     (req_lvl_i),
    .cnt_o         (cnt_o),
    .active_o      (active_o),
    .req_blocked_o (req_blocked_o)
);

// File: tb/intdis_timer_bench.sv
`timescale 1ns/1ps
module intdis_timer_bench;
    localparam int W = 14;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         tick = 0, cmd = 0, wr = 0, add = 0;
    logic [W-1:0] len = '0, dat = '0;
    logic [3:0]   lvl = '0;
    logic [W-1:0] cnt;
    logic         act, blk;

    int errors = 0, checks = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] cnt;
        string        tag;
    } exp_t;
    exp_t sb[$];
    logic [W-1:0] model = '0;

    always #5 clk = ~clk;

    intdis_timer u_intdis_timer (
        .clk(clk), .rst_n(rst_n), .cyc_tick_i(tick), .dis_cmd_i(cmd),
        .dis_len_i(len), .sw_wr_i(wr), .sw_add_i(add), .sw_data_i(dat),
        .req_lvl_i(lvl), .cnt_o(cnt), .active_o(act), .req_blocked_o(blk)
    );

    // Monitor: one expected item per driven cycle, compared after the edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (cnt !== e.cnt || act !== (e.cnt != '0)) begin
                errors++;
                $display("FAIL %s: cnt=%0d act=%0b expected cnt=%0d act=%0b",
                         e.tag, cnt, act, e.cnt, (e.cnt != '0));
            end
        end
    end

    task automatic step(input logic c, input logic [W-1:0] l, input logic w,
                        input logic a, input logic [W-1:0] d, input logic t,
                        input logic [3:0] lv, input string tag);
        logic [W-1:0] nx;
        logic [W:0]   s;
        logic         exp_blk;
        @(negedge clk);
        cmd = c; len = l; wr = w; add = a; dat = d; tick = t; lvl = lv;
        #1;
        exp_blk = (model != '0) && (lv >= 4'd1) && (lv <= 4'd6);
        checks++;
        if (blk !== exp_blk) begin
            errors++;
            $display("FAIL R4 (%s) lvl=%0d: blocked=%0b expected %0b", tag, lv, blk, exp_blk);
        end
        s = {1'b0, model} + {1'b0, d};
        if (c)                            nx = l;
        else if (w)                       nx = (model != '0) ? d : model;
        else if (a)                       nx = (model != '0) ? (s[W] ? {W{1'b1}} : s[W-1:0]) : model;
        else if (t && model != '0)        nx = model - 1'b1;
        else                              nx = model;
        sb.push_back('{nx, tag});
        model = nx;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cnt !== '0 || act !== 1'b0 || blk !== 1'b0) begin
            errors++;
            $display("FAIL R1: cnt=%0d act=%0b blk=%0b expected 0 0 0", cnt, act, blk);
        end
        rst_n = 1;

        // R6: writes and adds while idle never open a window
        step(0, 0, 1, 0, 14'd20, 1, 4'd3, "R6 write idle");
        step(0, 0, 0, 1, 14'd9,  0, 4'd3, "R6 add idle");
        // R2: command loads
        step(1, 14'd5, 0, 0, 0, 1, 4'd1, "R2 load 5 and R8 no decrement");
        // R3: continuous and gapped strobe, R4 level sweep
        step(0, 0, 0, 0, 0, 1, 4'd1, "R3 tick");
        step(0, 0, 0, 0, 0, 0, 4'd6, "R3 no tick");
        step(0, 0, 0, 0, 0, 1, 4'd7, "R3 tick lvl7");
        step(0, 0, 0, 0, 0, 0, 4'd9, "R3 hold trap lvl");
        step(0, 0, 0, 0, 0, 1, 4'd0, "R3 tick lvl0");
        // R5: write extends while busy
        step(0, 0, 1, 0, 14'd10, 1, 4'd15, "R5 write busy and R8 skip tick");
        // R7: add extends, then saturates
        step(0, 0, 0, 1, 14'd100, 1, 4'd2, "R7 add busy");
        step(0, 0, 1, 0, 14'd16380, 0, 4'd5, "R5 write near top");
        step(0, 0, 0, 1, 14'd100, 0, 4'd5, "R7 add saturate");
        // R8: collisions
        step(1, 14'd3, 1, 1, 14'd50, 1, 4'd4, "R8 cmd over write and add");
        step(0, 0, 1, 1, 14'd40, 1, 4'd4, "R8 write over add");
        // R5: write zero ends window
        step(0, 0, 1, 0, 14'd0, 0, 4'd4, "R5 write zero");
        step(0, 0, 0, 0, 0, 1, 4'd4, "R3 stays zero");
        step(0, 0, 1, 0, 14'd7, 1, 4'd4, "R6 write after end");
        // R2: max load and zero load
        step(1, 14'd16383, 0, 0, 0, 1, 4'd6, "R2 load max");
        step(0, 0, 0, 0, 0, 1, 4'd6, "R3 tick from max");
        step(1, 14'd0, 0, 0, 0, 1, 4'd6, "R2 load zero");
        // R3 run to zero, R9 flag follows
        step(1, 14'd2, 0, 0, 0, 0, 4'd6, "R2 load 2");
        step(0, 0, 0, 0, 0, 1, 4'd6, "R9 tick to 1");
        step(0, 0, 0, 0, 0, 1, 4'd6, "R9 tick to 0");
        step(0, 0, 0, 0, 0, 1, 4'd6, "R4 released");
        @(negedge clk); cmd = 0; wr = 0; add = 0; tick = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule